// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped block cache with a small fully associative victim buffer beside it. The buffer keeps the blocks that the main array has recently displaced. Each request reads or writes one 32-bit word. When the main array misses, the victim buffer is searched before memory is asked for the block. A victim hit exchanges the two blocks in a single step. The requested block returns to its main line, and the block that was in that line takes over the victim entry that just hit.

When both structures miss, the block is requested from the next memory level. When the fill arrives, the block it displaces from the main line is pushed into the victim buffer. If that push forces a dirty block out of the buffer, the block is written back to memory. The aim is to absorb conflict misses between a handful of blocks that share one main index, without adding latency to ordinary main-array hits.

One request is in flight at a time. A new request is taken only while `req_ready` is high.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req_valid` and `wb_valid` are 0. Every main line and every victim entry is empty, so the first access to any block fetches it from memory.
- R2: A request whose block is in the main array gets a one-cycle `rsp_valid` pulse with `rsp_kind` = 0, one clock after acceptance, and raises no memory request.
- R3: On a main-array miss the victim buffer is searched first. When it holds the block, `mem_req_valid` stays low for the whole request.
- R4: A victim hit answers with `rsp_kind` = 1, two clocks after acceptance. The block moves into its main line, so the next access to it hits the main array. The displaced main block takes the same victim entry, so a later access to it is a victim hit.
- R5: On a miss in both structures, `mem_req_valid` rises one clock after acceptance, with `mem_req_addr` = address bits [31:4]. It stays high, with that address unchanged, until the clock where `mem_fill_valid` is high. The response, with `rsp_kind` = 2, follows one clock after that clock.
- R6: On a fill, a valid block displaced from the main line is placed in the victim buffer. An empty main line places nothing.
- R7: A victim block is inserted into the lowest-numbered empty entry of the 4. When none is empty, it goes into the least recently used entry, where use means an insertion or a swap.
- R8: When an insertion pushes out a dirty victim entry, `wb_valid` pulses for one clock, in the same clock as the response, with that block's address and data. A clean entry that is pushed out produces no pulse.
- R9: A write replaces word `addr[3:2]` of the block (word 0 in bits 31:0) and marks the block dirty. The dirty bit and the data travel with the block between the two structures. `rsp_rdata` returns the word's value after the access.
- R10: The main array is indexed by `addr[9:4]` and tagged with `addr[31:10]`. Blocks with different indices never displace one another.
- R11: `req_ready` is low from the clock after acceptance until the response clock, and is low whenever `mem_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_addr | input | 32 | Byte address of the word |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_kind | output | 2 | 0 main hit, 1 victim hit, 2 memory fill |
| rsp_rdata | output | 32 | Word value after the access |
| mem_req_valid | output | 1 | Block fetch pending |
| mem_req_addr | output | 28 | Block address to fetch |
| mem_fill_valid | input | 1 | Fill data present |
| mem_fill_data | input | 128 | Fetched block |
| wb_valid | output | 1 | Dirty block pushed out of the victim buffer |
| wb_addr | output | 28 | Block address of the write-back |
| wb_data | output | 128 | Block data of the write-back |

## Verification
The acceptance edge is the reference for all timing. A main hit answers at the first clock after acceptance and a victim hit at the second. A miss raises `mem_req_valid` at the first clock and answers one clock after the fill is taken. The bench drives inputs and samples outputs on falling edges, and it counts falling edges from acceptance. It holds the fill back by a random 0 to 3 cycles, which makes the exact clock of every event known. Each response is checked for its latency against the kind the bench's own model predicts, and the write-back lines are read in the response clock.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int unsigned VC_ADDR_W    = 32;
  localparam int unsigned VC_BLK_BYTES = 16;
  localparam int unsigned VC_LINES     = 64;
  localparam int unsigned VC_VICT      = 4;
  localparam int unsigned VC_WORD_W    = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_SWAP = 2'd2,
    ST_MISS = 2'd3
  } vc_state_e;

  typedef enum logic [1:0] {
    RK_MAIN   = 2'd0,
    RK_VICTIM = 2'd1,
    RK_MEMORY = 2'd2
  } vc_kind_e;
endpackage

// File: rtl/vc_lru_ages.sv
// True LRU over ENTRIES slots (power of two). Each slot holds an age; the
// ages always form a permutation of 0..ENTRIES-1, and the oldest is the
// slot whose age is ENTRIES-1.
module vc_lru_ages #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [SLOT_W-1:0] touch_slot,
  output logic [SLOT_W-1:0] lru_slot
);
  logic [SLOT_W-1:0] age_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= SLOT_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (SLOT_W'(i) == touch_slot)            age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_slot])   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == SLOT_W'(ENTRIES - 1)) lru_slot = SLOT_W'(i);
  end
endmodule

// File: rtl/vc_dm_array.sv
// Direct-mapped line store: valid, tag, dirty and block data per line.
module vc_dm_array #(
  parameter int unsigned LINES = 64,
  parameter int unsigned TAG_W = 22,
  parameter int unsigned BLK_W = 128,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  output logic [BLK_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic [BLK_W-1:0] wr_data
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vc_victim_buf.sv
// Fully associative victim store tagged by the full block address.
module vc_victim_buf #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned BA_W    = 28,
  parameter int unsigned BLK_W   = 128,
  localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BA_W-1:0]   look_ba,
  output logic              look_hit,
  output logic [SLOT_W-1:0] look_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [BA_W-1:0]   rd_ba,
  output logic              rd_dirty,
  output logic [BLK_W-1:0]  rd_data,
  output logic [SLOT_W-1:0] repl_slot,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [BA_W-1:0]   wr_ba,
  input  logic              wr_dirty,
  input  logic [BLK_W-1:0]  wr_data
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [BA_W-1:0]    ba_q   [ENTRIES];
  logic [BLK_W-1:0]   data_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [SLOT_W-1:0]  lru_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_slot] <= wr_valid;
      dirty_q[wr_slot] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ba_q[wr_slot]   <= wr_ba;
      data_q[wr_slot] <= wr_data;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (ba_q[g] == look_ba);
  end

  assign look_hit = |match;

  always_comb begin
    look_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) look_slot = SLOT_W'(i);
  end

  // lowest empty slot wins; otherwise the least recently used one
  always_comb begin
    repl_slot = lru_slot;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) repl_slot = SLOT_W'(i);
  end

  assign rd_valid = valid_q[rd_slot];
  assign rd_dirty = dirty_q[rd_slot];
  assign rd_ba    = ba_q[rd_slot];
  assign rd_data  = data_q[rd_slot];

  vc_lru_ages #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (wr_en),
    .touch_slot (wr_slot),
    .lru_slot   (lru_slot)
  );
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
  import vc_pkg::*;
#(
  parameter int unsigned ADDR_W       = VC_ADDR_W,
  parameter int unsigned BLK_BYTES    = VC_BLK_BYTES,
  parameter int unsigned LINES        = VC_LINES,
  parameter int unsigned VICT_ENTRIES = VC_VICT,
  parameter int unsigned WORD_W       = VC_WORD_W,
  localparam int unsigned OFF_W  = $clog2(BLK_BYTES),
  localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W = OFF_W - BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned BA_W   = ADDR_W - OFF_W,
  localparam int unsigned BLK_W  = BLK_BYTES * 8,
  localparam int unsigned SLOT_W = $clog2(VICT_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic [BA_W-1:0]   mem_req_addr,
  input  logic              mem_fill_valid,
  input  logic [BLK_W-1:0]  mem_fill_data,
  output logic              wb_valid,
  output logic [BA_W-1:0]   wb_addr,
  output logic [BLK_W-1:0]  wb_data
);
  // ---------------- address arithmetic ----------------
  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [BA_W-1:0] f_block(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BA_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: WSEL_W];
  endfunction

  function automatic logic [WORD_W-1:0] f_get_word(input logic [BLK_W-1:0] b,
                                                   input logic [WSEL_W-1:0] s);
    return b[s*WORD_W +: WORD_W];
  endfunction

  function automatic logic [BLK_W-1:0] f_put_word(input logic [BLK_W-1:0] b,
                                                  input logic [WSEL_W-1:0] s,
                                                  input logic [WORD_W-1:0] w);
    logic [BLK_W-1:0] r;
    r = b;
    r[s*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  // ---------------- request registers ----------------
  vc_state_e         state_q;
  logic [ADDR_W-1:0] q_addr;
  logic              q_wr;
  logic [WORD_W-1:0] q_wdata;
  logic [SLOT_W-1:0] s_slot_q;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [BA_W-1:0]   cur_ba;
  logic [WSEL_W-1:0] cur_wsel;

  assign cur_idx  = f_index(q_addr);
  assign cur_tag  = f_tag(q_addr);
  assign cur_ba   = f_block(q_addr);
  assign cur_wsel = f_wsel(q_addr);

  // ---------------- main array ----------------
  logic             m_valid, m_dirty;
  logic [TAG_W-1:0] m_tag;
  logic [BLK_W-1:0] m_data;
  logic             dm_wr_en, dm_wr_dirty;
  logic [BLK_W-1:0] dm_wr_data;

  vc_dm_array #(.LINES(LINES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cur_idx),
    .rd_valid (m_valid),
    .rd_tag   (m_tag),
    .rd_dirty (m_dirty),
    .rd_data  (m_data),
    .wr_en    (dm_wr_en),
    .wr_idx   (cur_idx),
    .wr_tag   (cur_tag),
    .wr_dirty (dm_wr_dirty),
    .wr_data  (dm_wr_data)
  );

  // ---------------- victim buffer ----------------
  logic              vb_hit;
  logic [SLOT_W-1:0] vb_hit_slot, vb_rd_slot, vb_repl, vb_wr_slot;
  logic              vb_rd_valid, vb_rd_dirty, vb_wr_en;
  logic [BA_W-1:0]   vb_rd_ba;
  logic [BLK_W-1:0]  vb_rd_data;
  logic [BA_W-1:0]   displaced_ba;

  vc_victim_buf #(.ENTRIES(VICT_ENTRIES), .BA_W(BA_W), .BLK_W(BLK_W)) u_vict (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_ba   (cur_ba),
    .look_hit  (vb_hit),
    .look_slot (vb_hit_slot),
    .rd_slot   (vb_rd_slot),
    .rd_valid  (vb_rd_valid),
    .rd_ba     (vb_rd_ba),
    .rd_dirty  (vb_rd_dirty),
    .rd_data   (vb_rd_data),
    .repl_slot (vb_repl),
    .wr_en     (vb_wr_en),
    .wr_slot   (vb_wr_slot),
    .wr_valid  (m_valid),
    .wr_ba     (displaced_ba),
    .wr_dirty  (m_dirty),
    .wr_data   (m_data)
  );

  // ---------------- named events ----------------
  logic look_cycle, main_hit_w, ev_main_hit, ev_vic_hit, ev_miss, ev_swap, ev_fill;
  logic push_wb;

  assign look_cycle  = (state_q == ST_LOOK);
  assign main_hit_w  = m_valid && (m_tag == cur_tag);
  assign ev_main_hit = look_cycle && main_hit_w;
  assign ev_vic_hit  = look_cycle && !main_hit_w && vb_hit;
  assign ev_miss     = look_cycle && !main_hit_w && !vb_hit;
  assign ev_swap     = (state_q == ST_SWAP);
  assign ev_fill     = (state_q == ST_MISS) && mem_fill_valid;

  assign displaced_ba = {m_tag, cur_idx};
  assign vb_rd_slot   = ev_swap ? s_slot_q : vb_repl;
  assign vb_wr_slot   = ev_swap ? s_slot_q : vb_repl;
  assign vb_wr_en     = ev_swap || (ev_fill && m_valid);
  assign push_wb      = ev_fill && m_valid && vb_rd_valid && vb_rd_dirty;

  // ---------------- new main-line content ----------------
  logic [BLK_W-1:0] src_blk, new_blk;
  logic             src_dirty;

  always_comb begin
    if (ev_swap) begin
      src_blk   = vb_rd_data;
      src_dirty = vb_rd_dirty;
    end else if (ev_fill) begin
      src_blk   = mem_fill_data;
      src_dirty = 1'b0;
    end else begin
      src_blk   = m_data;
      src_dirty = m_dirty;
    end
    new_blk = q_wr ? f_put_word(src_blk, cur_wsel, q_wdata) : src_blk;
  end

  assign dm_wr_en    = (ev_main_hit && q_wr) || ev_swap || ev_fill;
  assign dm_wr_dirty = src_dirty || q_wr;
  assign dm_wr_data  = new_blk;

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      q_addr   <= '0;
      q_wr     <= 1'b0;
      q_wdata  <= '0;
      s_slot_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          state_q <= ST_LOOK;
          q_addr  <= req_addr;
          q_wr    <= req_wr;
          q_wdata <= req_wdata;
        end
        ST_LOOK: begin
          s_slot_q <= vb_hit_slot;
          if (main_hit_w)  state_q <= ST_IDLE;
          else if (vb_hit) state_q <= ST_SWAP;
          else             state_q <= ST_MISS;
        end
        ST_SWAP: state_q <= ST_IDLE;
        ST_MISS: if (mem_fill_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_kind      <= RK_MAIN;
      rsp_rdata     <= '0;
      mem_req_valid <= 1'b0;
      wb_valid      <= 1'b0;
      wb_addr       <= '0;
      wb_data       <= '0;
    end else begin
      rsp_valid <= ev_main_hit || ev_swap || ev_fill;
      if (ev_main_hit || ev_swap || ev_fill) begin
        rsp_rdata <= f_get_word(new_blk, cur_wsel);
        rsp_kind  <= ev_swap ? RK_VICTIM : (ev_fill ? RK_MEMORY : RK_MAIN);
      end
      if (ev_miss)      mem_req_valid <= 1'b1;
      else if (ev_fill) mem_req_valid <= 1'b0;
      wb_valid <= push_wb;
      if (push_wb) begin
        wb_addr <= vb_rd_ba;
        wb_data <= vb_rd_data;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_req_addr = cur_ba;
endmodule

// File: rtl/dm_victim_cache_chk.sv
module dm_victim_cache_chk #(
  parameter int unsigned BA_W = 28
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_kind,
  input logic            mem_req_valid,
  input logic [BA_W-1:0] mem_req_addr,
  input logic            mem_fill_valid,
  input logic            wb_valid,
  input logic            look_cycle,
  input logic            main_hit_w,
  input logic            vb_hit,
  input logic            ev_main_hit,
  input logic            ev_vic_hit,
  input logic            ev_miss
);
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_main_hit |=> rsp_valid && rsp_kind == 2'd0);

  a_r3_no_fetch_on_vhit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vic_hit |=> !mem_req_valid);

  a_r3_fetch_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(ev_miss));

  a_r4_swap_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vic_hit |=> !rsp_valid ##1 (rsp_valid && rsp_kind == 2'd1));

  a_r4_block_in_one_place: assert property (@(posedge clk) disable iff (!rst_n)
    look_cycle |-> !(main_hit_w && vb_hit));

  a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_fill_valid) |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_fill_response: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_fill_valid) |=> rsp_valid && rsp_kind == 2'd2 && !mem_req_valid);

  a_r8_wb_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rsp_valid && rsp_kind == 2'd2);

  a_r11_busy_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

bind dm_victim_cache dm_victim_cache_chk #(.BA_W(BA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_kind       (rsp_kind),
  .mem_req_valid  (mem_req_valid),
  .mem_req_addr   (mem_req_addr),
  .mem_fill_valid (mem_fill_valid),
  .wb_valid       (wb_valid),
  .look_cycle     (look_cycle),
  .main_hit_w     (main_hit_w),
  .vb_hit         (vb_hit),
  .ev_main_hit    (ev_main_hit),
  .ev_vic_hit     (ev_vic_hit),
  .ev_miss        (ev_miss)
);

// File: tb/dm_victim_cache_tb_top.sv
`timescale 1ns/1ps
module dm_victim_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         req_wr = 1'b0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [1:0]   rsp_kind;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid;
  logic [27:0]  mem_req_addr;
  logic         mem_fill_valid = 1'b0;
  logic [127:0] mem_fill_data = '0;
  logic         wb_valid;
  logic [27:0]  wb_addr;
  logic [127:0] wb_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dm_victim_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // ---------------- reference model ----------------
  logic         m_v   [64];
  logic [21:0]  m_tag [64];
  logic         m_d   [64];
  logic [127:0] m_dat [64];
  logic         v_v   [4];
  logic [27:0]  v_ba  [4];
  logic         v_d   [4];
  logic [127:0] v_dat [4];
  int           v_use [4];
  int           stamp = 0;
  logic [127:0] mem_store [logic [27:0]];

  function automatic logic [127:0] mem_read(input logic [27:0] ba);
    logic [27:0] k;
    if (mem_store.exists(ba)) return mem_store[ba];
    k = ba * 28'd3;
    return {ba ^ 28'h5a5a5a5, 4'h1, ~ba, 4'h2, k, 4'h3, ba + 28'd7, 4'h4};
  endfunction

  function automatic logic [31:0] mk_addr(input int tg, input int idx, input int w);
    return {22'(tg), 6'(idx), 2'(w), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // Updates the model for one access and returns what the ports must show.
  task automatic predict(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                         output int kind, output logic [31:0] word,
                         output bit wb, output logic [27:0] wb_ba, output logic [127:0] wb_dat);
    int idx, ws, hit, slot;
    logic [21:0] tg;
    logic [27:0] ba;
    logic [127:0] blk;
    bit dirty;
    idx = int'(a[9:4]); tg = a[31:10]; ba = a[31:4]; ws = int'(a[3:2]);
    wb = 0; wb_ba = '0; wb_dat = '0;
    if (m_v[idx] && m_tag[idx] == tg) begin
      kind = 0; blk = m_dat[idx]; dirty = m_d[idx];
    end else begin
      hit = -1;
      for (int s = 0; s < 4; s++) if (v_v[s] && v_ba[s] == ba) hit = s;
      if (hit >= 0) begin
        kind = 1; blk = v_dat[hit]; dirty = v_d[hit];
        v_v[hit] = m_v[idx]; v_ba[hit] = {m_tag[idx], 6'(idx)};
        v_d[hit] = m_d[idx]; v_dat[hit] = m_dat[idx];
        stamp++; v_use[hit] = stamp;
      end else begin
        kind = 2; blk = mem_read(ba); dirty = 0;
        if (m_v[idx]) begin
          slot = -1;
          for (int s = 3; s >= 0; s--) if (!v_v[s]) slot = s;
          if (slot < 0) begin
            slot = 0;
            for (int s = 1; s < 4; s++) if (v_use[s] < v_use[slot]) slot = s;
          end
          if (v_v[slot] && v_d[slot]) begin
            wb = 1; wb_ba = v_ba[slot]; wb_dat = v_dat[slot];
            mem_store[v_ba[slot]] = v_dat[slot];
          end
          v_v[slot] = 1; v_ba[slot] = {m_tag[idx], 6'(idx)};
          v_d[slot] = m_d[idx]; v_dat[slot] = m_dat[idx];
          stamp++; v_use[slot] = stamp;
        end
      end
    end
    if (wr) begin blk[ws*32 +: 32] = wd; dirty = 1; end
    m_v[idx] = 1; m_tag[idx] = tg; m_d[idx] = dirty; m_dat[idx] = blk;
    word = blk[ws*32 +: 32];
  endtask

  // One access: drive, serve the fill after a random delay, check the ports.
  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                        input string note);
    int kind, lat, fcyc, wc, d;
    logic [31:0] eword;
    bit ewb, got, sent, mreq_any, mreq_at1, busy_ok;
    logic [27:0] ewb_ba, rq_ba;
    logic [127:0] ewb_dat;
    logic [1:0] k_o; logic [31:0] w_o; logic wbv_o; logic [27:0] wba_o; logic [127:0] wbd_o;
    string rq;
    predict(a, wr, wd, kind, eword, ewb, ewb_ba, ewb_dat);
    rq = (kind == 0) ? "R2" : ((kind == 1) ? "R4" : "R5");
    d = int'($urandom_range(0, 3));
    @(negedge clk);
    req_valid = 1; req_addr = a; req_wr = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    busy_ok = !req_ready;
    got = 0; sent = 0; wc = 0; mreq_any = 0; mreq_at1 = 0; lat = 0; fcyc = 0; rq_ba = '0;
    k_o = '0; w_o = '0; wbv_o = 0; wba_o = '0; wbd_o = '0;
    for (int c = 1; c <= 16 && !got; c++) begin
      @(negedge clk);
      mem_fill_valid = 0;
      if (rsp_valid) begin
        got = 1; lat = c; k_o = rsp_kind; w_o = rsp_rdata;
        wbv_o = wb_valid; wba_o = wb_addr; wbd_o = wb_data;
        chk(req_ready, "R11", {note, " ready at response"}, 128'(req_ready), 128'd1);
      end else begin
        if (!req_ready) ; else busy_ok = 0;
        if (mem_req_valid) begin
          mreq_any = 1;
          if (c == 1) begin mreq_at1 = 1; rq_ba = mem_req_addr; end
          if (!sent) begin
            if (wc == d) begin
              mem_fill_valid = 1; mem_fill_data = mem_read(mem_req_addr);
              sent = 1; fcyc = c;
            end else wc++;
          end
        end
      end
    end
    chk(busy_ok, "R11", {note, " ready low while busy"}, 128'(busy_ok), 128'd1);
    chk(got, rq, {note, " response arrived"}, 128'(got), 128'd1);
    chk(k_o == 2'(kind), rq, {note, " kind"}, 128'(k_o), 128'(kind));
    chk(w_o == eword, wr ? "R9" : rq, {note, " word"}, 128'(w_o), 128'(eword));
    if (kind == 0) begin
      chk(lat == 1, "R2", {note, " latency"}, 128'(lat), 128'd1);
      chk(!mreq_any, "R2", {note, " no fetch"}, 128'(mreq_any), 128'd0);
    end else if (kind == 1) begin
      chk(lat == 2, "R4", {note, " latency"}, 128'(lat), 128'd2);
      chk(!mreq_any, "R3", {note, " victim searched before memory"}, 128'(mreq_any), 128'd0);
    end else begin
      chk(mreq_at1, "R5", {note, " fetch one cycle after accept"}, 128'(mreq_at1), 128'd1);
      chk(rq_ba == a[31:4], "R5", {note, " fetch address"}, 128'(rq_ba), 128'(a[31:4]));
      chk(lat == fcyc + 1, "R5", {note, " latency after fill"}, 128'(lat), 128'(fcyc + 1));
    end
    chk(wbv_o == ewb, "R8", {note, " write-back pulse"}, 128'(wbv_o), 128'(ewb));
    if (ewb) begin
      chk(wba_o == ewb_ba, "R8", {note, " write-back address"}, 128'(wba_o), 128'(ewb_ba));
      chk(wbd_o == ewb_dat, "R8", {note, " write-back data"}, wbd_o, ewb_dat);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog: act=hung exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_d[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    for (int s = 0; s < 4; s++) begin v_v[s] = 0; v_d[s] = 0; v_ba[s] = '0; v_dat[s] = '0; v_use[s] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req_valid == 0 && wb_valid == 0,
        "R1", "outputs in reset", {124'd0, req_ready, rsp_valid, mem_req_valid, wb_valid}, 128'h8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req_valid == 0 && wb_valid == 0,
        "R1", "outputs after reset", {124'd0, req_ready, rsp_valid, mem_req_valid, wb_valid}, 128'h8);

    // directed: one index, growing conflict set
    access(mk_addr(1, 5, 0), 0, 0,            "R1 cold miss");
    access(mk_addr(1, 5, 2), 1, 32'hdead0001, "R9 write hit");
    access(mk_addr(1, 6, 0), 0, 0,            "R10 other index");
    access(mk_addr(1, 5, 2), 0, 0,            "R10 no displacement");
    access(mk_addr(2, 5, 1), 0, 0,            "R6 displace into victim");
    access(mk_addr(1, 5, 2), 0, 0,            "R4 swap back dirty");
    access(mk_addr(1, 5, 2), 0, 0,            "R4 now in main");
    access(mk_addr(2, 5, 1), 1, 32'hbeef0002, "R4 displaced block found");
    access(mk_addr(3, 5, 0), 0, 0,            "R7 fill slot");
    access(mk_addr(4, 5, 0), 0, 0,            "R7 fill slot");
    access(mk_addr(5, 5, 0), 0, 0,            "R7 fill slot");
    access(mk_addr(6, 5, 0), 0, 0,            "R7 pushout LRU");
    access(mk_addr(7, 5, 0), 0, 0,            "R8 pushout");
    access(mk_addr(1, 5, 2), 0, 0,            "R8 refetch written data");
    access(mk_addr(2, 5, 1), 0, 0,            "R8 refetch written data");

    // random mix on a few conflicting indices
    for (int n = 0; n < 400; n++) begin
      int ix, tg, w;
      bit wr;
      ix = (n % 3 == 0) ? 40 : ((n % 3 == 1) ? 5 : int'($urandom_range(5, 6)));
      tg = int'($urandom_range(0, 6));
      w  = int'($urandom_range(0, 3));
      wr = ($urandom_range(0, 9) < 4);
      access(mk_addr(tg, ix, w), wr, $urandom, "random");
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule